// File: doc/BRIEF.md
# Stereo Serial Audio Sample Receiver

This block takes stereo audio samples in two's-complement form from a serial link and hands each left/right pair to a downstream modulator. All of its logic runs on the serial bit clock. The word clock comes in as an input and is sampled on that clock. Data bits are shifted in on every rising bit-clock edge, most significant bit first. A word is taken at a word-clock transition.

Two stereo layouts are supported. In dual-line mode each channel has its own data pin, and both channels are taken together when the word clock falls. In shared-line mode one pin carries the left word and then the right word. The left word is taken when the word clock rises and the right word when it falls. The pair goes to the modulator on the next rise of the word clock. In shared-line mode the unused left pin turns into a word-clock delay control.

A two-bit code selects a word length of 16, 18 or 20 bits. Shorter words are left-justified in the 20-bit sample outputs.

Top module: `stereo_ser_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first sample is issued, both sample outputs are zero and the strobe is low.
- R2: A word is formed from the last N bits sampled on the data pin before the word-clock boundary, taking the earliest as the most significant bit. Any earlier bits are discarded.
- R3: The length code on `res_sel` maps 2'b00 to 16 bits, 2'b01 to 18 bits, and both 2'b10 and 2'b11 to 20 bits.
- R4: A word shorter than 20 bits fills the upper bits of its sample output, and the unused low bits read zero.
- R5: In dual-line mode (`mux_mode`=0), `din_a` is the left data and `din_b` is the right data. If edge k is the first rising bit-clock edge that samples the word clock low after it was high, both outputs update and the strobe is high after edge k+1.
- R6: In shared-line mode (`mux_mode`=1), `din_b` carries the data. The word before a rising word-clock boundary is the left sample and the word before a falling boundary is the right sample.
- R7: In shared-line mode, a pair is issued at the rise that follows a fall: if edge k is the first edge that samples the word clock high, the outputs update and the strobe is high after edge k+1. A rise with no prior fall since reset issues nothing.
- R8: In shared-line mode with `din_a` high, the word clock is treated as one bit-clock cycle later. The boundary therefore includes one more data bit, and the strobe comes one cycle later.
- R9: The strobe is high for exactly one cycle, and the sample outputs change only in a cycle where the strobe is high.
- R10: In dual-line mode a rising word-clock edge issues no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk | input | 1 | Word clock, sampled on bit clock |
| din_a | input | 1 | Left data (dual-line) or word-clock delay control (shared-line) |
| din_b | input | 1 | Right data (dual-line) or shared left-then-right data |
| mux_mode | input | 1 | 0 selects dual-line, 1 selects shared-line |
| res_sel | input | 2 | Word length code |
| smp_left | output | 20 | Left sample, left-justified |
| smp_right | output | 20 | Right sample, left-justified |
| smp_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Let edge k be the first bit-clock edge that samples a new word-clock level. The strobe and the new samples are then due after edge k+1, or after edge k+2 when the delay control is active in shared-line mode. The bench records the edge count at which it drives each boundary bit and schedules the expected pair for exactly that later edge. The expected pair comes from its own history of the driven bits. A monitor reads the outputs at each falling bit-clock edge. It fails a missing strobe in the due cycle and any strobe in any other cycle, which covers the ignored rises in dual-line mode and the first rise in shared-line mode.

// File: rtl/stereo_ser_rx_pkg.sv
package stereo_ser_rx_pkg;
  // word length codes; 2'b11 aliases the full length
  typedef enum logic [1:0] {
    LEN_SHORT    = 2'b00,
    LEN_MID      = 2'b01,
    LEN_FULL     = 2'b10,
    LEN_FULL_ALT = 2'b11
  } len_code_e;

  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_L    = 0;
  localparam int unsigned LANE_R    = 1;
endpackage

// File: rtl/stereo_ser_rx_wsync.sv
module stereo_ser_rx_wsync (
  input  logic bclk,
  input  logic rst_n,
  input  logic wclk,
  input  logic dly_en,
  output logic rise,
  output logic fall
);
  logic st1_q, st1_d;
  logic st2_q, st2_d;
  logic prev_q, prev_d;
  logic eff;

  // optional extra stage realises the one-cycle word clock delay
  always_comb begin
    st1_d  = wclk;
    st2_d  = st1_q;
    eff    = dly_en ? st2_q : st1_q;
    prev_d = eff;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q  <= 1'b0;
      st2_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      st1_q  <= st1_d;
      st2_q  <= st2_d;
      prev_q <= prev_d;
    end
  end

  assign rise = eff & ~prev_q;
  assign fall = ~eff & prev_q;
endmodule

// File: rtl/stereo_ser_rx_lane.sv
module stereo_ser_rx_lane
  import stereo_ser_rx_pkg::*;
#(
  parameter int unsigned OUT_W   = 20,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned MID_W   = 18
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [1:0]       res_sel,
  output logic [OUT_W-1:0] word
);
  localparam int unsigned SR_W = OUT_W + 1;
  localparam int unsigned SH_W = $clog2(OUT_W + 1);
  localparam logic [SH_W-1:0] SH_SHORT = SH_W'(OUT_W - SHORT_W);
  localparam logic [SH_W-1:0] SH_MID   = SH_W'(OUT_W - MID_W);

  logic [SR_W-1:0] sr_q, sr_d;
  logic [SH_W-1:0] sh;

  always_comb sr_d = {sr_q[SR_W-2:0], din};

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  always_comb begin
    case (len_code_e'(res_sel))
      LEN_SHORT: sh = SH_SHORT;
      LEN_MID:   sh = SH_MID;
      default:   sh = '0;
    endcase
  end

  // bit 0 is the newest sample, taken in the capture cycle itself;
  // the word ends one bit earlier, and the shift drops the leading bits
  assign word = sr_q[SR_W-1:1] << sh;
endmodule

// File: rtl/stereo_ser_rx.sv
module stereo_ser_rx
  import stereo_ser_rx_pkg::*;
#(
  parameter int unsigned OUT_W   = 20,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned MID_W   = 18
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             wclk,
  input  logic             din_a,
  input  logic             din_b,
  input  logic             mux_mode,
  input  logic [1:0]       res_sel,
  output logic [OUT_W-1:0] smp_left,
  output logic [OUT_W-1:0] smp_right,
  output logic             smp_valid
);
  // reset: asserted at once, released after two bit clocks
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic ws_rise, ws_fall;

  stereo_ser_rx_wsync u_wsync (
    .bclk   (bclk),
    .rst_n  (rst_int_n),
    .wclk   (wclk),
    .dly_en (mux_mode & din_a),
    .rise   (ws_rise),
    .fall   (ws_fall)
  );

  logic [NUM_LANES-1:0] din_vec;
  logic [OUT_W-1:0]     lane_word [NUM_LANES];
  assign din_vec = {din_b, din_a};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    stereo_ser_rx_lane #(
      .OUT_W   (OUT_W),
      .SHORT_W (SHORT_W),
      .MID_W   (MID_W)
    ) u_lane (
      .bclk    (bclk),
      .rst_n   (rst_int_n),
      .din     (din_vec[g]),
      .res_sel (res_sel),
      .word    (lane_word[g])
    );
  end

  logic [OUT_W-1:0] out_l_q, out_l_d, out_r_q, out_r_d;
  logic [OUT_W-1:0] hold_l_q, hold_l_d, hold_r_q, hold_r_d;
  logic             have_r_q, have_r_d;
  logic             vld_q, vld_d;
  logic             out_en, hold_l_en, hold_r_en;

  // enables
  always_comb begin
    if (!mux_mode) begin
      out_en    = ws_fall;
      hold_l_en = 1'b0;
      hold_r_en = 1'b0;
    end else begin
      out_en    = ws_rise & have_r_q;
      hold_l_en = ws_rise;
      hold_r_en = ws_fall;
    end
  end

  // next state
  always_comb begin
    vld_d    = out_en;
    out_l_d  = out_l_q;
    out_r_d  = out_r_q;
    hold_l_d = hold_l_q;
    hold_r_d = hold_r_q;
    have_r_d = have_r_q;
    if (out_en) begin
      out_l_d = mux_mode ? hold_l_q : lane_word[LANE_L];
      out_r_d = mux_mode ? hold_r_q : lane_word[LANE_R];
    end
    if (hold_l_en) hold_l_d = lane_word[LANE_R];
    if (hold_r_en) hold_r_d = lane_word[LANE_R];
    if (!mux_mode)     have_r_d = 1'b0;
    else if (ws_fall)  have_r_d = 1'b1;
    else if (ws_rise)  have_r_d = 1'b0;
  end

  always_ff @(posedge bclk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_l_q  <= '0;
      out_r_q  <= '0;
      hold_l_q <= '0;
      hold_r_q <= '0;
      have_r_q <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      out_l_q  <= out_l_d;
      out_r_q  <= out_r_d;
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      have_r_q <= have_r_d;
      vld_q    <= vld_d;
    end
  end

  assign smp_left  = out_l_q;
  assign smp_right = out_r_q;
  assign smp_valid = vld_q;
endmodule

// File: rtl/stereo_ser_rx_chk.sv
module stereo_ser_rx_chk #(
  parameter int unsigned OUT_W   = 20,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned MID_W   = 18
) (
  input logic             bclk,
  input logic             rst_n,
  input logic [1:0]       res_sel,
  input logic [OUT_W-1:0] smp_left,
  input logic [OUT_W-1:0] smp_right,
  input logic             smp_valid
);
  // R9
  strobe_single_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R9
  out_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !smp_valid |-> ($stable(smp_left) && $stable(smp_right)));

  // R4
  fill16_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (smp_valid && $past(res_sel) == 2'b00) |->
      (smp_left[OUT_W-SHORT_W-1:0] == '0 && smp_right[OUT_W-SHORT_W-1:0] == '0));

  // R4
  fill18_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (smp_valid && $past(res_sel) == 2'b01) |->
      (smp_left[OUT_W-MID_W-1:0] == '0 && smp_right[OUT_W-MID_W-1:0] == '0));
endmodule

bind stereo_ser_rx stereo_ser_rx_chk #(
  .OUT_W   (OUT_W),
  .SHORT_W (SHORT_W),
  .MID_W   (MID_W)
) u_chk (
  .bclk      (bclk),
  .rst_n     (rst_int_n),
  .res_sel   (res_sel),
  .smp_left  (smp_left),
  .smp_right (smp_right),
  .smp_valid (smp_valid)
);

// File: tb/stereo_ser_rx_test.sv
`timescale 1ns/1ps
module stereo_ser_rx_test;
  logic        bclk = 1'b0;
  logic        rst_n, wclk, din_a, din_b, mux_mode;
  logic [1:0]  res_sel;
  logic [19:0] smp_left, smp_right;
  logic        smp_valid;

  int n_chk = 0, n_err = 0, cyc = 0, due = -1, stray = 0;
  logic [19:0] exp_l, exp_r, hold_l, hold_r, hist_a, hist_b;
  logic        have_r, prev_w, running = 1'b0;
  string       due_tag;

  stereo_ser_rx uut (
    .bclk(bclk), .rst_n(rst_n), .wclk(wclk), .din_a(din_a), .din_b(din_b),
    .mux_mode(mux_mode), .res_sel(res_sel),
    .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid)
  );

  always #10 bclk = ~bclk;
  always @(posedge bclk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // R3 length codes, R4 left justification with zero fill
  function automatic logic [19:0] align(input logic [19:0] h, input logic [1:0] r);
    int n;
    n = (r == 2'b00) ? 16 : (r == 2'b01) ? 18 : 20;
    return h << (20 - n);
  endfunction

  always @(negedge bclk) begin
    if (running) begin
      if (cyc == due) begin
        check(smp_valid == 1'b1, {due_tag, " strobe"}, {19'd0, smp_valid}, 20'd1);
        check(smp_left == exp_l, {due_tag, " R2 R3 R4 left"}, smp_left, exp_l);
        check(smp_right == exp_r, {due_tag, " R2 R3 R4 right"}, smp_right, exp_r);
        due = -1;
      end else if (smp_valid) begin
        stray++;
        check(1'b0, "R9 R10 stray strobe", {19'd0, smp_valid}, 20'd0);
      end
    end
  end

  task automatic drive_bit(input logic w, input logic a, input logic b);
    logic        d;
    logic [19:0] wa, wb;
    @(negedge bclk);
    d = mux_mode && a;
    if (w != prev_w) begin
      wa = align(hist_a, res_sel);
      wb = d ? align({hist_b[18:0], b}, res_sel) : align(hist_b, res_sel);
      if (!mux_mode) begin
        if (!w) begin
          due = cyc + 2; exp_l = wa; exp_r = wb; due_tag = "R5";
        end
      end else if (w) begin
        if (have_r) begin
          due = cyc + 2 + (d ? 1 : 0); exp_l = hold_l; exp_r = hold_r;
          due_tag = d ? "R6 R7 R8" : "R6 R7";
        end
        have_r = 1'b0;
        hold_l = wb;
      end else begin
        hold_r = wb;
        have_r = 1'b1;
      end
    end
    hist_a = {hist_a[18:0], a};
    hist_b = {hist_b[18:0], b};
    prev_w = w;
    wclk = w; din_a = a; din_b = b;
  endtask

  task automatic do_reset(input logic mux, input logic dly, input logic [1:0] r);
    running = 1'b0;
    @(negedge bclk);
    rst_n = 1'b0; wclk = 1'b0; din_a = mux ? dly : 1'b0; din_b = 1'b0;
    mux_mode = mux; res_sel = r;
    prev_w = 1'b0; hist_a = '0; hist_b = '0; have_r = 1'b0; due = -1; stray = 0;
    repeat (2) @(negedge bclk);
    check(smp_left == 20'd0 && smp_right == 20'd0, "R1 reset samples", smp_left, 20'd0);
    check(smp_valid == 1'b0, "R1 reset strobe", {19'd0, smp_valid}, 20'd0);
    rst_n = 1'b1;
    running = 1'b1;
    for (int i = 0; i < 4; i++) drive_bit(1'b0, din_a, 1'b0);
    check(smp_left == 20'd0 && smp_valid == 1'b0, "R1 after release", smp_left, 20'd0);
  endtask

  function automatic logic [19:0] pick(input int mode, input int f);
    logic [19:0] tbl [5];
    tbl = '{20'h80000, 20'h7FFFF, 20'hFFFFF, 20'h00001, 20'h00000};
    if (mode == 0) return tbl[f % 5];
    return 20'($urandom);
  endfunction

  task automatic run_seg(input logic mux, input logic dly, input logic [1:0] r,
                         input int frames, input int mode);
    int n;
    logic [19:0] wl, wr;
    logic a;
    do_reset(mux, dly, r);
    n = (r == 2'b00) ? 16 : (r == 2'b01) ? 18 : 20;
    a = mux ? dly : 1'b0;
    for (int f = 0; f < frames; f++) begin
      wl = pick(mode, f);
      wr = pick(mode, f + 2);
      if (!mux) begin
        // R2 leading junk bits are discarded
        for (int j = 0; j < int'($urandom_range(0, 3)); j++)
          drive_bit(1'b1, 1'($urandom), 1'($urandom));
        for (int i = 0; i < n; i++) drive_bit(1'b1, wl[19-i], wr[19-i]);
        for (int j = 0; j < int'($urandom_range(1, 4)); j++)
          drive_bit(1'b0, 1'($urandom), 1'($urandom));
      end else begin
        for (int j = 0; j < int'($urandom_range(0, 3)); j++) drive_bit(1'b0, a, 1'($urandom));
        for (int i = 0; i < n; i++) drive_bit(1'b0, a, wl[19-i]);
        for (int j = 0; j < int'($urandom_range(0, 3)); j++) drive_bit(1'b1, a, 1'($urandom));
        for (int i = 0; i < n; i++) drive_bit(1'b1, a, wr[19-i]);
      end
    end
    if (mux) begin
      for (int i = 0; i < n; i++) drive_bit(1'b0, a, 1'($urandom));
      for (int i = 0; i < 6; i++) drive_bit(1'b1, a, 1'($urandom));
    end else begin
      for (int i = 0; i < 6; i++) drive_bit(1'b0, 1'b0, 1'b0);
    end
    check(due == -1, "R5 R7 pending strobe not seen", 20'(due), 20'hFFFFF);
    check(stray == 0, "R10 no strobe on ignored edges", 20'(stray), 20'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wclk = 1'b0; din_a = 1'b0; din_b = 1'b0; mux_mode = 1'b0; res_sel = 2'b10;
    run_seg(1'b0, 1'b0, 2'b10, 5, 0);
    run_seg(1'b0, 1'b0, 2'b00, 5, 0);
    run_seg(1'b0, 1'b0, 2'b01, 6, 1);
    run_seg(1'b0, 1'b0, 2'b11, 6, 1);
    run_seg(1'b1, 1'b0, 2'b10, 5, 0);
    run_seg(1'b1, 1'b0, 2'b00, 6, 1);
    run_seg(1'b1, 1'b1, 2'b01, 6, 1);
    run_seg(1'b1, 1'b1, 2'b10, 5, 0);
    for (int s = 0; s < 8; s++)
      run_seg(1'($urandom), 1'($urandom), 2'($urandom), 5, 1);
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule